// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits in the instruction fetch path of an 8-bit processor with a 16-bit address space. Instruction bytes arrive one at a time over a valid/ready handshake. The block recognises an optional page prebyte and classifies the opcode into an addressing mode. It collects any operand bytes, then presents a single result for the whole instruction. The result holds the effective address, the total length in bytes and the program counter of the next instruction, which accounts for a taken branch. For immediate instructions it holds the operand byte.

The caller supplies four values. The first is the address of the first byte of the instruction, sampled when that byte is accepted. The other three are the two index registers and the B accumulator, sampled with the branch condition when the last byte of the instruction is accepted. The mode comes from the opcode's upper nibble, so no full opcode table is needed. A prebyte of 0x18 switches indexed addressing and the add-B-to-index operation from IX to IY. A prebyte that comes before any other opcode is reported as illegal.

Top module: `opnd_ea_gen`

## Requirements
- R1: `byteReady` is high in every cycle except one. That cycle directly follows the clock edge that accepts the last byte of an instruction. In that cycle exactly one of `eaValid` or `illegalOp` is high for one cycle. The outputs `eaAddr`, `instLen`, `nextPc`, `addrMode` and `operandData` keep their values until the next result.
- R2: The opcode's upper nibble sets `addrMode`: 0x2 is relative (5), 0x8 or 0xC is immediate (1), 0x9 or 0xD is direct (2), 0xA or 0xE is indexed (4), 0xB or 0xF is extended (3), and every other value is inherent (0).
- R3: An extended instruction takes two operand bytes, high byte first. `eaAddr` is {high, low} and `instLen` is 3.
- R4: An indexed instruction takes one operand byte. `eaAddr` is IX plus the zero-extended byte, modulo 2^16, and `instLen` is 2.
- R5: The prebyte 0x18 ahead of an indexed opcode makes `eaAddr` IY plus the zero-extended offset, modulo 2^16. `instLen` is then 3.
- R6: A direct instruction takes one operand byte. `eaAddr` is 0x00 followed by that byte, and `instLen` is 2.
- R7: An immediate instruction takes one operand byte. `operandData` is that byte, `eaAddr` is 0 and `instLen` is 2.
- R8: A relative instruction takes one offset byte. `eaAddr` is the PC plus 2 plus the sign-extended offset, modulo 2^16. `nextPc` is that target when `branchTaken` is high and PC plus 2 when it is low. `instLen` is 2.
- R9: An inherent instruction has no operand bytes and `instLen` is 1. `eaAddr` is 0, except for opcode 0x3A, where it is IX plus the zero-extended `bVal`. With the prebyte, 0x3A uses IY and `instLen` is 2.
- R10: The prebyte followed by an opcode that is neither indexed nor 0x3A causes a pulse on `illegalOp` and none on `eaValid`. `instLen` is 2, `eaAddr` is 0 and `nextPc` is the PC plus 2.
- R11: For every non-relative result, `nextPc` equals the PC sampled with the first byte of the instruction plus `instLen`, modulo 2^16.
- R12: In reset and in the first cycle after it, `byteReady` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Instruction byte offered |
| byteData | input | 8 | Instruction byte |
| byteReady | output | 1 | Block can accept a byte |
| ixVal | input | 16 | Index register X |
| iyVal | input | 16 | Index register Y |
| pcVal | input | 16 | Address of the instruction's first byte |
| bVal | input | 8 | B accumulator, used by opcode 0x3A |
| branchTaken | input | 1 | Branch condition for relative instructions |
| eaValid | output | 1 | One-cycle result strobe |
| illegalOp | output | 1 | One-cycle strobe for a misused prebyte |
| eaAddr | output | 16 | Effective address or branch target |
| instLen | output | 3 | Bytes in the instruction, prebyte included |
| nextPc | output | 16 | Address of the next instruction to run |
| addrMode | output | 3 | Addressing mode code |
| operandData | output | 8 | Immediate operand byte |

## Verification
The hardest situation to reach is a result whose inputs were sampled on different edges. The PC is sampled with the first byte, while the index registers, B and the branch flag are sampled with the last byte, and gaps in `byteValid` separate those edges. To reach it, the bench changes every side input on every cycle, inserts random idle cycles between bytes and streams random opcodes mixed with prebytes. Directed cases cover index sums that wrap past 0xFFFF and backward branches that wrap below 0x0000.

// File: rtl/opea_pkg.sv
package opea_pkg;
  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_IMM = 3'd1,
    MODE_DIR = 3'd2,
    MODE_EXT = 3'd3,
    MODE_IDX = 3'd4,
    MODE_REL = 3'd5
  } addrMode_e;

  typedef struct packed {
    addrMode_e  mode;
    logic [1:0] nOps;
    logic       addIdx;
    logic       iyOk;
  } opInfo_t;

  typedef struct packed {
    logic capPc;
    logic capPre;
    logic capOpc;
    logic capOp1;
    logic finish;
    logic badPre;
  } ctrlStrobe_t;
endpackage

// File: rtl/opea_decode.sv
module opea_decode
  import opea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ADDIDX_CODE = 8'h3A
) (
  input  logic [DATA_W-1:0] opc,
  output opInfo_t           info
);
  logic [3:0] hiNib;
  assign hiNib = opc[DATA_W-1 -: 4];

  always_comb begin
    info = '0;
    unique case (hiNib)
      4'h2:        info.mode = MODE_REL;
      4'h8, 4'hC:  info.mode = MODE_IMM;
      4'h9, 4'hD:  info.mode = MODE_DIR;
      4'hA, 4'hE:  info.mode = MODE_IDX;
      4'hB, 4'hF:  info.mode = MODE_EXT;
      default:     info.mode = MODE_INH;
    endcase
    case (info.mode)
      MODE_EXT: info.nOps = 2'd2;
      MODE_INH: info.nOps = 2'd0;
      default:  info.nOps = 2'd1;
    endcase
    info.addIdx = (opc == ADDIDX_CODE);
    info.iyOk   = (info.mode == MODE_IDX) || info.addIdx;
  end
endmodule

// File: rtl/opea_ctrl.sv
module opea_ctrl
  import opea_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PRE_CODE    = 8'h18,
  parameter logic [DATA_W-1:0] ADDIDX_CODE = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic              byteReady,
  output ctrlStrobe_t       strb
);
  typedef enum logic [2:0] {
    ST_FIRST, ST_AFTERPRE, ST_OPER1, ST_OPER2, ST_SHOW
  } ctrlState_e;

  ctrlState_e state, stateNext;
  logic       needTwo, needTwoNext;
  logic       acc;
  opInfo_t    info;

  opea_decode #(.DATA_W(DATA_W), .ADDIDX_CODE(ADDIDX_CODE)) uDec (
    .opc (byteData),
    .info(info)
  );

  assign byteReady = (state != ST_SHOW);
  assign acc       = byteValid && byteReady;

  always_comb begin
    stateNext   = state;
    needTwoNext = needTwo;
    strb        = '0;
    case (state)
      ST_FIRST: if (acc) begin
        strb.capPc = 1'b1;
        if (byteData == PRE_CODE) begin
          strb.capPre = 1'b1;
          stateNext   = ST_AFTERPRE;
        end else begin
          strb.capOpc = 1'b1;
          needTwoNext = (info.nOps == 2'd2);
          if (info.nOps == 2'd0) begin
            strb.finish = 1'b1;
            stateNext   = ST_SHOW;
          end else begin
            stateNext = ST_OPER1;
          end
        end
      end
      ST_AFTERPRE: if (acc) begin
        strb.capOpc = 1'b1;
        needTwoNext = (info.nOps == 2'd2);
        if (!info.iyOk) begin
          strb.badPre = 1'b1;
          strb.finish = 1'b1;
          stateNext   = ST_SHOW;
        end else if (info.nOps == 2'd0) begin
          strb.finish = 1'b1;
          stateNext   = ST_SHOW;
        end else begin
          stateNext = ST_OPER1;
        end
      end
      ST_OPER1: if (acc) begin
        strb.capOp1 = 1'b1;
        if (needTwo) begin
          stateNext = ST_OPER2;
        end else begin
          strb.finish = 1'b1;
          stateNext   = ST_SHOW;
        end
      end
      ST_OPER2: if (acc) begin
        strb.finish = 1'b1;
        stateNext   = ST_SHOW;
      end
      default: stateNext = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FIRST;
      needTwo <= 1'b0;
    end else begin
      state   <= stateNext;
      needTwo <= needTwoNext;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !byteReady);
  assert_ready_back_R1: assert property (@(posedge clk) disable iff (!rstN)
    !byteReady |=> byteReady);
  assert_badpre_only_after_pre_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.badPre |-> $past(strb.capPre) || (state == ST_AFTERPRE));
endmodule

// File: rtl/opea_dp.sv
module opea_dp
  import opea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ADDIDX_CODE = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] ixVal,
  input  logic [ADDR_W-1:0] iyVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DATA_W-1:0] bVal,
  input  logic              branchTaken,
  output logic              eaValid,
  output logic              illegalOp,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [2:0]        instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic [2:0]        addrMode,
  output logic [DATA_W-1:0] operandData
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcReg;
  logic              preReg;
  logic [DATA_W-1:0] opcReg;
  logic [DATA_W-1:0] op1Reg;

  logic [DATA_W-1:0] effOpc;
  logic              effPre;
  logic [ADDR_W-1:0] pcBase;
  logic [ADDR_W-1:0] idxSel;
  logic [DATA_W-1:0] idxOff;
  logic [ADDR_W-1:0] idxSum;
  logic [ADDR_W-1:0] relTgt;
  logic [ADDR_W-1:0] seqNext;
  logic [2:0]        lenCalc;
  logic [ADDR_W-1:0] addrCalc;
  logic [ADDR_W-1:0] nextCalc;
  opInfo_t           info;

  opea_decode #(.DATA_W(DATA_W), .ADDIDX_CODE(ADDIDX_CODE)) uDec (
    .opc (effOpc),
    .info(info)
  );

  assign effOpc = strb.capOpc ? byteData : opcReg;
  assign effPre = strb.capPc ? 1'b0 : preReg;
  assign pcBase = strb.capPc ? pcVal : pcReg;
  assign idxSel = effPre ? iyVal : ixVal;
  assign idxOff = info.addIdx ? bVal : byteData;
  assign idxSum = idxSel + {{EXT_W{1'b0}}, idxOff};
  assign relTgt = pcBase + ADDR_W'(2) + {{EXT_W{byteData[DATA_W-1]}}, byteData};

  always_comb begin
    if (strb.badPre) lenCalc = 3'd2;
    else             lenCalc = 3'd1 + 3'(effPre) + 3'(info.nOps);
  end
  assign seqNext = pcBase + ADDR_W'(lenCalc);

  always_comb begin
    addrCalc = '0;
    nextCalc = seqNext;
    if (!strb.badPre) begin
      case (info.mode)
        MODE_EXT: addrCalc = ADDR_W'({op1Reg, byteData});
        MODE_IDX: addrCalc = idxSum;
        MODE_DIR: addrCalc = {{EXT_W{1'b0}}, byteData};
        MODE_REL: begin
          addrCalc = relTgt;
          nextCalc = branchTaken ? relTgt : seqNext;
        end
        MODE_INH: addrCalc = info.addIdx ? idxSum : '0;
        default:  addrCalc = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg  <= '0;
      preReg <= 1'b0;
      opcReg <= '0;
      op1Reg <= '0;
    end else begin
      if (strb.capPc)  pcReg  <= pcVal;
      if (strb.capPc)  preReg <= strb.capPre;
      if (strb.capOpc) opcReg <= byteData;
      if (strb.capOp1) op1Reg <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaValid     <= 1'b0;
      illegalOp   <= 1'b0;
      eaAddr      <= '0;
      instLen     <= '0;
      nextPc      <= '0;
      addrMode    <= '0;
      operandData <= '0;
    end else begin
      eaValid   <= strb.finish && !strb.badPre;
      illegalOp <= strb.finish && strb.badPre;
      if (strb.finish) begin
        eaAddr   <= addrCalc;
        instLen  <= lenCalc;
        nextPc   <= nextCalc;
        addrMode <= info.mode;
        if (!strb.badPre && info.mode == MODE_IMM) operandData <= byteData;
      end
    end
  end

  assert_one_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> !eaValid);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(eaValid && illegalOp));
  assert_illegal_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (instLen == 3'd2) && (eaAddr == '0));
  assert_direct_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eaValid && addrMode == 3'(MODE_DIR)) |-> (eaAddr[ADDR_W-1:DATA_W] == '0));
  assert_imm_noaddr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (eaValid && addrMode == 3'(MODE_IMM)) |-> (eaAddr == '0));
  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |-> (instLen >= 3'd1) && (instLen <= 3'd4));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(eaAddr) && $stable(nextPc));
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PRE_CODE    = 8'h18,
  parameter logic [DATA_W-1:0] ADDIDX_CODE = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic              byteReady,
  input  logic [ADDR_W-1:0] ixVal,
  input  logic [ADDR_W-1:0] iyVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DATA_W-1:0] bVal,
  input  logic              branchTaken,
  output logic              eaValid,
  output logic              illegalOp,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [2:0]        instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic [2:0]        addrMode,
  output logic [DATA_W-1:0] operandData
);
  ctrlStrobe_t strb;

  opea_ctrl #(.DATA_W(DATA_W), .PRE_CODE(PRE_CODE), .ADDIDX_CODE(ADDIDX_CODE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .byteReady(byteReady),
    .strb     (strb)
  );

  opea_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDIDX_CODE(ADDIDX_CODE)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .byteData   (byteData),
    .ixVal      (ixVal),
    .iyVal      (iyVal),
    .pcVal      (pcVal),
    .bVal       (bVal),
    .branchTaken(branchTaken),
    .eaValid    (eaValid),
    .illegalOp  (illegalOp),
    .eaAddr     (eaAddr),
    .instLen    (instLen),
    .nextPc     (nextPc),
    .addrMode   (addrMode),
    .operandData(operandData)
  );

  assert_ready_at_reset_R12: assert property (@(posedge clk)
    $past(!rstN) |-> byteReady && !eaValid && !illegalOp);
endmodule

// File: tb/opnd_ea_gen_test.sv
module opnd_ea_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteReady;
  logic [15:0] ixVal = '0, iyVal = '0, pcVal = '0;
  logic [7:0]  bVal = '0;
  logic        branchTaken = 1'b0;
  logic        eaValid, illegalOp;
  logic [15:0] eaAddr, nextPc;
  logic [2:0]  instLen, addrMode;
  logic [7:0]  operandData;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  opnd_ea_gen uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .ixVal(ixVal), .iyVal(iyVal), .pcVal(pcVal),
    .bVal(bVal), .branchTaken(branchTaken), .eaValid(eaValid),
    .illegalOp(illegalOp), .eaAddr(eaAddr), .instLen(instLen),
    .nextPc(nextPc), .addrMode(addrMode), .operandData(operandData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected outputs (reference model)
  logic        eReady = 1'b1, eValid = 1'b0, eIll = 1'b0;
  logic [15:0] eAddr = '0, eNext = '0;
  logic [2:0]  eLen = '0, eMode = '0;
  logic [7:0]  eData = '0;
  string       eTag = "R12";
  string       nTag = "R12";

  // model state
  int          mSt = 0;
  bit          mPre = 0;
  logic [15:0] mPc = '0;
  logic [7:0]  mOpc = '0;
  logic [7:0]  mOps[$];
  int          mNeed = 0;

  logic [7:0]  stream[$];
  int          sp = 0;

  function automatic int modeOf(logic [7:0] op);
    case (op[7:4])
      4'h2: return 5;
      4'h8, 4'hC: return 1;
      4'h9, 4'hD: return 2;
      4'hA, 4'hE: return 4;
      4'hB, 4'hF: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int opsOf(logic [7:0] op);
    int md = modeOf(op);
    if (md == 3) return 2;
    if (md == 0) return 0;
    return 1;
  endfunction

  function automatic bit iyLegal(logic [7:0] op);
    return (modeOf(op) == 4) || (op == 8'h3A);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    check(byteReady === eReady, "R1", "byteReady", int'(byteReady), int'(eReady));
    check(eaValid === eValid, "R1", "eaValid", int'(eaValid), int'(eValid));
    check(illegalOp === eIll, "R10", "illegalOp", int'(illegalOp), int'(eIll));
    check(eaAddr === eAddr, eTag, "eaAddr", int'(eaAddr), int'(eAddr));
    check(instLen === eLen, eTag, "instLen", int'(instLen), int'(eLen));
    check(nextPc === eNext, (eTag == "R8") ? "R8" : "R11", "nextPc", int'(nextPc), int'(eNext));
    check(addrMode === eMode, "R2", "addrMode", int'(addrMode), int'(eMode));
    check(operandData === eData, "R7", "operandData", int'(operandData), int'(eData));
  endtask

  task automatic finishInstr(input bit ill);
    int md = modeOf(mOpc);
    int len;
    logic [15:0] idx, tgt, seq;
    eMode = 3'(md);
    if (ill) begin
      eIll = 1; eAddr = '0; eLen = 3'd2; eNext = mPc + 16'd2; eTag = "R10";
    end else begin
      eValid = 1;
      len = 1 + int'(mPre) + opsOf(mOpc);
      eLen = 3'(len);
      seq = mPc + 16'(len);
      eNext = seq;
      idx = mPre ? iyVal : ixVal;
      case (md)
        3: begin eAddr = {mOps[0], mOps[1]}; eTag = "R3"; end
        4: begin eAddr = idx + {8'h00, mOps[0]}; eTag = mPre ? "R5" : "R4"; end
        2: begin eAddr = {8'h00, mOps[0]}; eTag = "R6"; end
        1: begin eAddr = '0; eData = mOps[0]; eTag = "R7"; end
        5: begin
          tgt = mPc + 16'd2 + {{8{mOps[0][7]}}, mOps[0]};
          eAddr = tgt;
          eNext = branchTaken ? tgt : seq;
          eTag = "R8";
        end
        default: begin
          eAddr = (mOpc == 8'h3A) ? idx + {8'h00, bVal} : 16'h0000;
          eTag = "R9";
        end
      endcase
    end
    mSt = 3;
  endtask

  task automatic startOpc(input logic [7:0] op);
    mOpc = op;
    mNeed = opsOf(op);
    mOps.delete();
    if (mNeed == 0) finishInstr(0);
    else mSt = 2;
  endtask

  // advance the model across the coming posedge
  task automatic stepModel();
    bit acc = byteValid && eReady;
    eValid = 0;
    eIll = 0;
    case (mSt)
      3: mSt = 0;
      0: if (acc) begin
        mPc = pcVal;
        if (byteData == 8'h18) begin mPre = 1; mSt = 1; end
        else begin mPre = 0; startOpc(byteData); end
      end
      1: if (acc) begin
        if (!iyLegal(byteData)) begin mOpc = byteData; finishInstr(1); end
        else startOpc(byteData);
      end
      default: if (acc) begin
        mOps.push_back(byteData);
        if (mOps.size() == mNeed) finishInstr(0);
      end
    endcase
    eReady = (mSt != 3);
    if (acc) sp++;
  endtask

  task automatic push(input logic [7:0] a);
    stream.push_back(a);
  endtask

  initial begin
    // directed program
    push(8'hB9); push(8'h12); push(8'h34);           // R3 extended
    push(8'hF9); push(8'hFF); push(8'hFE);           // R3 extended
    push(8'hA9); push(8'h10);                        // R4 indexed IX
    push(8'hA9); push(8'hFF);                        // R4 wrap
    push(8'h18); push(8'hA9); push(8'h80);           // R5 indexed IY
    push(8'h18); push(8'hE9); push(8'hF0);           // R5
    push(8'h99); push(8'h42);                        // R6 direct
    push(8'h89); push(8'h7F);                        // R7 immediate
    push(8'h20); push(8'h05);                        // R8 forward
    push(8'h26); push(8'h80);                        // R8 backward
    push(8'h1B);                                     // R9 inherent
    push(8'h3A);                                     // R9 add B to IX
    push(8'h18); push(8'h3A);                        // R9 add B to IY
    push(8'h18); push(8'h89);                        // R10 illegal
    push(8'h18); push(8'h1B);                        // R10 illegal
    push(8'h18); push(8'h18);                        // R10 illegal
    push(8'hC9); push(8'h01);
    // random program
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op = 8'($urandom);
      if ($urandom % 5 == 0) begin
        push(8'h18);
        if ($urandom % 10 < 7) op = ($urandom % 2) ? {4'hA, 4'($urandom)} : 8'h3A;
        push(op);
        if (iyLegal(op)) for (int j = 0; j < opsOf(op); j++) push(8'($urandom));
      end else begin
        if (op == 8'h18) op = 8'h19;
        push(op);
        for (int j = 0; j < opsOf(op); j++) push(8'($urandom));
      end
    end

    // reset phase, R12
    rstN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      cycles++;
      compareAll();
    end
    rstN = 1'b1;

    while (!(sp >= stream.size() && mSt == 0)) begin
      @(negedge clk);
      cycles++;
      compareAll();
      if (cycles > 150000) begin
        check(0, "R1", "watchdog expired", cycles, 0);
        break;
      end
      ixVal = ($urandom % 4 == 0) ? {8'hFF, 8'($urandom)} : 16'($urandom);
      iyVal = ($urandom % 4 == 0) ? {8'hFF, 8'($urandom)} : 16'($urandom);
      pcVal = ($urandom % 4 == 0) ? {8'h00, 8'($urandom)} : 16'($urandom);
      bVal = 8'($urandom);
      branchTaken = 1'($urandom);
      byteValid = (sp < stream.size()) && ($urandom % 4 != 0);
      byteData = byteValid ? stream[sp] : 8'($urandom);
      stepModel();
    end
    byteValid = 1'b0;
    stepModel();
    @(negedge clk);
    compareAll();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule